// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge Interrupts

This block controls four banks of 32 general-purpose pins through one word-addressed register port. For each pin it holds an output value, a direction bit, separate enables for rising-edge and falling-edge detection, a sticky edge-status bit and an interrupt enable. The pad inputs pass through a two-stage synchronizer. The selected edges are then detected and latched into the status bits. One interrupt line goes high while any latched and enabled status bit is set.

Software can write the direction and edge-enable words directly. It can also use write-only alias addresses that only set, or only clear, the bits written as 1, so no read-modify-write is needed. Output bits are changed only through set and clear aliases. Status bits are cleared by writing 1 to them.

The four banks share one window. Register kinds are 3 words apart inside a bank. Banks 0, 1 and 2 are interleaved at word bases 0, 1 and 2. Bank 3 starts at word 64.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every output, direction, edge-enable, status and interrupt-enable bit is 0, so `irq`, `pad_out` and `pad_oe` are all 0.
- R2: A register's word address is the bank base plus 3 times its kind index. The bank bases are 0, 1, 2 and 64. The kind indices are: 0 pin level (read-only), 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status, 7 direction set, 8 direction clear, 9 rising set, 10 rising clear, 11 falling set, 12 falling clear, 13 interrupt enable. An access reaches only the addressed bank.
- R3: A write to output set drives the output bits written as 1 to 1. A write to output clear drives them to 0. All other bits keep their value.
- R4: A direct write to direction replaces the whole word. Direction set and direction clear change only the bits written as 1. `pad_oe` equals the direction bits, and `pad_out` equals output AND direction.
- R5: The rising-enable and falling-enable words can be written directly, which replaces the whole word. Their set and clear aliases change only the bits written as 1. Both words read back.
- R6: Reads of write-only kinds (2, 3, 7 to 12) and of unmapped word addresses return 0. Writes to unmapped addresses change nothing.
- R7: A pin-level read returns the pad input after two synchronizer stages. A pad change driven before clock edge k shows up in a read issued at edge k+2.
- R8: A synchronized 0-to-1 transition on a pin with rising enable set, or a 1-to-0 transition on a pin with falling enable set, sets that pin's status bit. A pad change before edge k sets the status bit at edge k+2. Transitions on pins without the matching enable set nothing.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge sets a bit in the same cycle that it is being cleared, the bit ends up set.
- R10: `irq` is high exactly when some bank has a bit that is set in both status and the interrupt-enable word.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. In every other cycle `bus_rdata` is 0. A read in the same cycle as a write returns the value from before the write.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 128 | Pad input levels, 32 per bank, bank 0 in the low bits |
| pad_out | output | 128 | Pad output values, gated by direction |
| pad_oe | output | 128 | Pad output enables (the direction bits) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus strobes and the address are known values in every cycle after reset. The status assertions also assume that pad inputs reach the state only through the synchronizer, so a status bit can rise only after an enabled transition has been seen.

The stimulus meets these assumptions as follows:
- It drives every input from time zero.
- It changes inputs only on falling clock edges.
- It holds the pads low through reset.
- It never raises read and write together in its random phase.

Directed sequences time pad changes so that an edge and a clear of the same status bit land on the same clock edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [3:0] {
        RK_LEVEL    = 4'd0,
        RK_DIR      = 4'd1,
        RK_OUT_SET  = 4'd2,
        RK_OUT_CLR  = 4'd3,
        RK_RISE     = 4'd4,
        RK_FALL     = 4'd5,
        RK_STATUS   = 4'd6,
        RK_DIR_SET  = 4'd7,
        RK_DIR_CLR  = 4'd8,
        RK_RISE_SET = 4'd9,
        RK_RISE_CLR = 4'd10,
        RK_FALL_SET = 4'd11,
        RK_FALL_CLR = 4'd12,
        RK_MASK     = 4'd13
    } reg_kind_e;

    localparam int KIND_COUNT    = 14;
    localparam int KIND_STRIDE   = 3;
    localparam int NEAR_BANKS    = 3;
    localparam int FAR_BANK_BASE = 64;

    // Word base of a bank: the first three banks are interleaved from 0,
    // and any further bank is interleaved from the far base.
    function automatic int bank_base_word(input int bank);
        if (bank < NEAR_BANKS)
            return bank;
        return FAR_BANK_BASE + (bank - NEAR_BANKS);
    endfunction

endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 7
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] bank_sel_o,
    output reg_kind_e            kind_o,
    output logic                 hit_o
);

    always_comb begin
        bank_sel_o = '0;
        kind_o     = RK_LEVEL;
        hit_o      = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int k = 0; k < KIND_COUNT; k++) begin
                if (int'(addr_i) == bank_base_word(b) + k * KIND_STRIDE) begin
                    bank_sel_o[b] = 1'b1;
                    kind_o        = reg_kind_e'(4'(k));
                    hit_o         = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_edge_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  reg_kind_e       kind_i,
    input  logic [PINS-1:0] wdata_i,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] rd_data_o,
    output logic [PINS-1:0] pad_out_o,
    output logic [PINS-1:0] pad_oe_o,
    output logic            irq_o
);

    logic [PINS-1:0] level, level_q;
    logic [PINS-1:0] dir_q, out_q, rise_q, fall_q, st_q, mask_q;
    logic [PINS-1:0] dir_d, out_d, rise_d, fall_d, st_d, mask_d;
    logic [PINS-1:0] edge_evt, w1c_bits;
    logic [KIND_COUNT-1:0] wr_kind;

    gpio_input_sync #(.WIDTH(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .sync_o  (level)
    );

    // One-hot write strobe per register kind
    assign wr_kind = wr_en_i ? (KIND_COUNT'(1) << kind_i) : '0;

    function automatic logic [PINS-1:0] apply_write(
        input logic [PINS-1:0] cur,
        input logic            full,
        input logic            set,
        input logic            clr,
        input logic [PINS-1:0] d
    );
        if (full)
            return d;
        if (set)
            return cur | d;
        if (clr)
            return cur & ~d;
        return cur;
    endfunction

    // Synchronized transitions, filtered by the per-pin enables
    assign edge_evt = (level & ~level_q & rise_q) | (~level & level_q & fall_q);
    assign w1c_bits = wr_kind[RK_STATUS] ? wdata_i : '0;

    always_comb begin
        out_d  = apply_write(out_q,  1'b0, wr_kind[RK_OUT_SET], wr_kind[RK_OUT_CLR], wdata_i);
        dir_d  = apply_write(dir_q,  wr_kind[RK_DIR], wr_kind[RK_DIR_SET], wr_kind[RK_DIR_CLR], wdata_i);
        rise_d = apply_write(rise_q, wr_kind[RK_RISE], wr_kind[RK_RISE_SET], wr_kind[RK_RISE_CLR], wdata_i);
        fall_d = apply_write(fall_q, wr_kind[RK_FALL], wr_kind[RK_FALL_SET], wr_kind[RK_FALL_CLR], wdata_i);
        mask_d = apply_write(mask_q, wr_kind[RK_MASK], 1'b0, 1'b0, wdata_i);
        st_d   = (st_q & ~w1c_bits) | edge_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            out_q   <= '0;
            dir_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            st_q    <= '0;
            mask_q  <= '0;
        end else begin
            level_q <= level;
            out_q   <= out_d;
            dir_q   <= dir_d;
            rise_q  <= rise_d;
            fall_q  <= fall_d;
            st_q    <= st_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        unique case (kind_i)
            RK_LEVEL:    rd_data_o = level;
            RK_DIR:      rd_data_o = dir_q;
            RK_RISE:     rd_data_o = rise_q;
            RK_FALL:     rd_data_o = fall_q;
            RK_STATUS:   rd_data_o = st_q;
            RK_MASK:     rd_data_o = mask_q;
            RK_OUT_SET, RK_OUT_CLR,
            RK_DIR_SET, RK_DIR_CLR,
            RK_RISE_SET, RK_RISE_CLR,
            RK_FALL_SET, RK_FALL_CLR: rd_data_o = '0;
            default:     rd_data_o = '0;
        endcase
    end

    assign pad_oe_o  = dir_q;
    assign pad_out_o = out_q & dir_q;
    assign irq_o     = |(st_q & mask_q);

    AST_STATUS_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_kind[RK_STATUS] |=> ((st_q & $past(st_q)) == $past(st_q)));      // R9
    AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(edge_evt)) == '0));         // R8
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_kind[RK_OUT_SET] || wr_kind[RK_OUT_CLR]) |=> $stable(out_q));   // R3
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_kind[RK_DIR] || wr_kind[RK_DIR_SET] || wr_kind[RK_DIR_CLR]) |=> $stable(pad_oe_o)); // R4

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 32,
    parameter int ADDR_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [PINS-1:0]           bus_wdata,
    output logic [PINS-1:0]           bus_rdata,
    input  logic [NUM_BANKS*PINS-1:0] pad_in,
    output logic [NUM_BANKS*PINS-1:0] pad_out,
    output logic [NUM_BANKS*PINS-1:0] pad_oe,
    output logic                      irq
);

    localparam int TOTAL_PINS = NUM_BANKS * PINS;

    logic [NUM_BANKS-1:0] bank_sel;
    logic [NUM_BANKS-1:0] bank_irq;
    reg_kind_e            kind;
    logic                 hit;
    logic [PINS-1:0]      bank_rd [NUM_BANKS];
    logic [PINS-1:0]      rd_mux;

    gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr_i     (bus_addr),
        .bank_sel_o (bank_sel),
        .kind_o     (kind),
        .hit_o      (hit)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        gpio_bank #(.PINS(PINS)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bus_wr && bank_sel[g]),
            .kind_i    (kind),
            .wdata_i   (bus_wdata),
            .pad_i     (pad_in[g*PINS +: PINS]),
            .rd_data_o (bank_rd[g]),
            .pad_out_o (pad_out[g*PINS +: PINS]),
            .pad_oe_o  (pad_oe[g*PINS +: PINS]),
            .irq_o     (bank_irq[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel[b])
                rd_mux = rd_mux | bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= (bus_rd && hit) ? rd_mux : '0;
    end

    assign irq = |bank_irq;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));                                      // R11
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == '0));                             // R6
    AST_BANK_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));                                                 // R2
    AST_PAD_WIDTH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == {TOTAL_PINS{1'b0}}));                        // R4

endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pad_in = '0;
    logic [127:0] pad_out, pad_oe;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit mdl_live = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0]  m_out[4], m_dir[4], m_re[4], m_fe[4], m_st[4], m_mask[4];
    logic [127:0] m_s1, m_s2, m_s3;
    logic [31:0]  m_rdata;

    function automatic bit mdl_decode(input int a, output int b, output int t);
        if (a < 64) begin
            b = a % 3;
            t = a / 3;
            return t < 14;
        end
        b = 3;
        t = (a - 64) / 3;
        return ((a - 64) % 3 == 0) && (t < 14);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_out[i] = 0; m_dir[i] = 0; m_re[i] = 0;
                m_fe[i] = 0; m_st[i] = 0; m_mask[i] = 0;
            end
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rdata = 0;
        end else begin
            int b, t;
            bit ok;
            logic [31:0] v, d, clr;
            logic [31:0] ev[4];
            ok = mdl_decode(int'(bus_addr), b, t);
            v = 0;
            if (ok) begin
                case (t)
                    0: v = m_s2[b*32 +: 32];
                    1: v = m_dir[b];
                    4: v = m_re[b];
                    5: v = m_fe[b];
                    6: v = m_st[b];
                    13: v = m_mask[b];
                    default: v = 0;
                endcase
            end
            m_rdata = bus_rd ? v : 32'h0;
            for (int i = 0; i < 4; i++) begin
                logic [31:0] now_l, old_l;
                now_l = m_s2[i*32 +: 32];
                old_l = m_s3[i*32 +: 32];
                ev[i] = (now_l & ~old_l & m_re[i]) | (~now_l & old_l & m_fe[i]);
            end
            clr = 0;
            d = bus_wdata;
            if (bus_wr && ok) begin
                case (t)
                    1:  m_dir[b] = d;
                    2:  m_out[b] = m_out[b] | d;
                    3:  m_out[b] = m_out[b] & ~d;
                    4:  m_re[b] = d;
                    5:  m_fe[b] = d;
                    6:  clr = d;
                    7:  m_dir[b] = m_dir[b] | d;
                    8:  m_dir[b] = m_dir[b] & ~d;
                    9:  m_re[b] = m_re[b] | d;
                    10: m_re[b] = m_re[b] & ~d;
                    11: m_fe[b] = m_fe[b] | d;
                    12: m_fe[b] = m_fe[b] & ~d;
                    13: m_mask[b] = d;
                    default: ;
                endcase
            end
            for (int i = 0; i < 4; i++) begin
                if (bus_wr && ok && i == b)
                    m_st[i] = (m_st[i] & ~clr) | ev[i];
                else
                    m_st[i] = m_st[i] | ev[i];
            end
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (mdl_live && rst_n) begin
            logic [127:0] e_out, e_oe;
            logic e_irq;
            e_irq = 0;
            for (int i = 0; i < 4; i++) begin
                e_out[i*32 +: 32] = m_out[i] & m_dir[i];
                e_oe[i*32 +: 32]  = m_dir[i];
                e_irq = e_irq | (|(m_st[i] & m_mask[i]));
            end
            chk("R4 pad_out vs model", pad_out, e_out);
            chk("R4 pad_oe vs model", pad_oe, e_oe);
            chk("R10 irq vs model", {127'b0, irq}, {127'b0, e_irq});
            chk("R11 rdata vs model", {96'b0, bus_rdata}, {96'b0, m_rdata});
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [6:0] adr(input int b, input int k);
        return 7'((b < 3 ? b : 64) + 3 * k);
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        chk(tag, {96'b0, bus_rdata}, {96'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        mdl_live = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {127'b0, irq}, 128'h0);
        chk("R1 pad_oe after reset", pad_oe, 128'h0);
        chk("R1 pad_out after reset", pad_out, 128'h0);
        rd_chk(adr(3, 13), 32'h0, "R1 mask bank3 reset");
        rd_chk(adr(0, 6), 32'h0, "R1 status bank0 reset");

        // R3 / R4 output and direction
        wr(adr(0, 2), 32'hF0F0_0000);
        wr(adr(0, 1), 32'hFFFF_0000);
        chk("R4 pad_oe bank0", {96'b0, pad_oe[31:0]}, {96'b0, 32'hFFFF_0000});
        chk("R3 pad_out after set", {96'b0, pad_out[31:0]}, {96'b0, 32'hF0F0_0000});
        wr(adr(0, 3), 32'h1000_0000);
        chk("R3 pad_out after clear", {96'b0, pad_out[31:0]}, {96'b0, 32'hE0F0_0000});
        rd_chk(adr(0, 1), 32'hFFFF_0000, "R4 dir bank0 readback");
        wr(adr(1, 7), 32'h0000_00FF);
        wr(adr(1, 8), 32'h0000_000F);
        rd_chk(adr(1, 1), 32'h0000_00F0, "R4 dir set/clear bank1");

        // R2 bank separation, far bank
        wr(adr(3, 1), 32'hA5A5_A5A5);
        rd_chk(adr(3, 1), 32'hA5A5_A5A5, "R2 bank3 dir at word 67");
        rd_chk(adr(2, 1), 32'h0, "R2 bank2 untouched");
        chk("R2 pad_oe bank3", {96'b0, pad_oe[127:96]}, {96'b0, 32'hA5A5_A5A5});

        // R5 edge enables
        wr(adr(2, 9), 32'h3);
        wr(adr(2, 10), 32'h1);
        rd_chk(adr(2, 4), 32'h2, "R5 rise set/clear");
        wr(adr(2, 5), 32'hFFFF_0000);
        wr(adr(2, 11), 32'h1);
        rd_chk(adr(2, 5), 32'hFFFF_0001, "R5 fall direct plus set");

        // R6 write-only and unmapped
        rd_chk(adr(0, 2), 32'h0, "R6 read of output-set alias");
        rd_chk(adr(1, 12), 32'h0, "R6 read of falling-clear alias");
        rd_chk(7'd42, 32'h0, "R6 unmapped read 42");
        rd_chk(7'd127, 32'h0, "R6 unmapped read 127");
        wr(7'd42, 32'hFFFF_FFFF);
        rd_chk(adr(0, 1), 32'hFFFF_0000, "R6 unmapped write ignored");

        // R7 level and latency
        pad_in[63:32] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rd_chk(adr(1, 0), 32'h1234_5678, "R7 level bank1");
        pad_in[0] = 1'b1;
        rd_chk(adr(0, 0), 32'h0, "R7 level not yet at k");
        rd_chk(adr(0, 0), 32'h0, "R7 level not yet at k+1");
        rd_chk(adr(0, 0), 32'h1, "R7 level at k+2");

        // R8 edge detection on bank2 (pin1 rising, pin0 falling)
        pad_in[65] = 1'b1;
        repeat (3) @(negedge clk);
        pad_in[64] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(adr(2, 6), 32'h2, "R8 rise sets, rise on fall-only pin ignored");
        pad_in[64] = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(adr(2, 6), 32'h3, "R8 falling edge sets pin0");
        pad_in[65] = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk(adr(2, 6), 32'h3, "R8 fall on rise-only pin ignored");

        // R10 interrupt enable
        chk("R10 irq masked", {127'b0, irq}, 128'h0);
        wr(adr(2, 13), 32'h2);
        chk("R10 irq enabled", {127'b0, irq}, 128'h1);

        // R9 write-one-to-clear and set wins
        wr(adr(2, 6), 32'h2);
        chk("R9 irq after clear", {127'b0, irq}, 128'h0);
        rd_chk(adr(2, 6), 32'h1, "R9 only written bit cleared");
        pad_in[65] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(adr(2, 6), 32'h2);
        rd_chk(adr(2, 6), 32'h3, "R9 set wins over clear");
        chk("R9 irq after set wins", {127'b0, irq}, 128'h1);

        // Random phase, compared per cycle against the model
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if (op == 0) begin
                pad_in[$urandom_range(0, 127)] ^= 1'b1;
                @(negedge clk);
            end else if (op <= 2) begin
                wr(adr(int'($urandom_range(0, 3)), int'($urandom_range(0, 13))), $urandom);
            end else if (op == 3) begin
                wr(7'($urandom_range(0, 127)), $urandom);
            end else begin
                bus_rd = 1;
                bus_addr = 7'($urandom_range(0, 127));
                @(negedge clk);
                bus_rd = 0;
            end
        end
        repeat (4) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule